// File: doc/BRIEF.md
# Privilege Mode and Trap Controller

This block keeps the current privilege level of a small in-order core and performs every controlled change of that level. Decode sends it single-cycle requests with the PC of the instruction that raised them. The requests are an environment call, a supervisor return, an attempt at a privileged instruction, and a generic synchronous fault that carries its own cause code. On a trap the block records the trapping PC, the mode the core was in and a numeric cause. It then switches to supervisor mode and, one cycle later, asserts a redirect whose target is computed from a table base that only supervisor or machine code can load. The trapping program has no influence on that target.

A supervisor return is the only path back to a less privileged mode. It restores the saved mode and redirects to the saved PC. When the saved cause is an environment call, the target is the saved PC plus 4, so the core resumes after the call. The handler address is the table base plus 4 times the cause code. Each kind of exception therefore owns its own slot in the table.

Top module: `priv_trap_ctrl`

## Requirements
- R1: After reset the mode output is machine (2'b11), the table base is zero, the redirect output is low and the previous-mode output is user (2'b00).
- R2: Modes are encoded user 2'b00, supervisor 2'b01, hypervisor 2'b10, machine 2'b11. An environment call traps with cause 8 from user, 9 from supervisor and 11 from machine.
- R3: A trap stores the request's PC in the exception PC, the current mode in the previous mode and the cause in the cause register, and it sets the mode to supervisor. These updates all land on the same clock edge.
- R4: A supervisor return issued in supervisor or machine mode sets the mode to the saved previous mode and sets the previous mode to user. It redirects to the exception PC plus 4 when the saved cause is 8, 9 or 11, and to the exception PC otherwise. User mode is entered only through such a return.
- R5: A privileged instruction or a supervisor return attempted in user mode is an illegal-instruction trap with cause 2.
- R6: An accepted table-base write stores the written value with its two low bits forced to zero.
- R7: A table-base write issued while the mode is user is ignored, and the table base keeps its value.
- R8: When several requests arrive in one cycle, priority is illegal instruction, then environment call, then fault, then valid supervisor return. Only the winner takes effect.
- R9: A fault request traps with the cause taken from the fault-cause input.
- R10: A trap redirects, on the cycle after the request, to table base + 4 × cause, using the table base held when the request arrived. Redirect is high for exactly the one cycle after each accepted trap or return and low otherwise, and the target holds its value while redirect is low.
- R11: A privileged instruction attempted in supervisor or machine mode causes no trap, no redirect and no change of mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecall_i | input | 1 | Environment-call request pulse |
| sret_i | input | 1 | Supervisor-return request pulse |
| priv_op_i | input | 1 | Privileged-instruction attempt pulse |
| fault_i | input | 1 | Other synchronous fault pulse |
| fault_cause_i | input | CAUSE_W | Cause code accompanying fault_i |
| pc_i | input | XLEN | PC of the requesting instruction |
| tbase_wr_i | input | 1 | Table-base write strobe |
| tbase_wdata_i | input | XLEN | Table-base write data |
| redirect_o | output | 1 | Fetch redirect valid (registered) |
| target_o | output | XLEN | Redirect target PC (registered) |
| mode_o | output | 2 | Current privilege mode |
| prev_mode_o | output | 2 | Saved previous mode |
| epc_o | output | XLEN | Saved exception PC |
| cause_o | output | CAUSE_W | Saved cause code |
| tbase_o | output | XLEN | Handler table base |

## Verification
The assertions are checked on every clock. They confirm that every trap lands in supervisor mode, that a return restores the saved mode, and that user mode is entered only through a return. They also confirm that a user-mode table-base write leaves the base unchanged, that an accepted write aligns the base, and that a trap's target equals the earlier table base plus four times the recorded cause. The directed scenarios are needed to show the rest. These cover the exact cause numbers chosen per mode, the priority outcome when requests collide, the plus-4 resume after an environment call versus re-execution after a fault, and the full round trip from machine mode down to user mode and back through each kind of trap.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

  localparam logic [1:0] MODE_USR = 2'b00;
  localparam logic [1:0] MODE_SUP = 2'b01;
  localparam logic [1:0] MODE_HYP = 2'b10;
  localparam logic [1:0] MODE_MCH = 2'b11;

  localparam int CODE_ILLEGAL = 2;
  localparam int CODE_CALL_USR = 8;
  localparam int CODE_CALL_SUP = 9;
  localparam int CODE_CALL_MCH = 11;

  typedef enum logic [1:0] {
    EVT_NONE  = 2'd0,
    EVT_TRAP  = 2'd1,
    EVT_RET   = 2'd2
  } evt_e;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import priv_trap_pkg::*;
#(
  parameter int CAUSE_W = 5
) (
  input  logic [1:0]         mode_i,
  input  logic               ecall_i,
  input  logic               sret_i,
  input  logic               priv_op_i,
  input  logic               fault_i,
  input  logic [CAUSE_W-1:0] fault_cause_i,
  output evt_e               evt_o,
  output logic [CAUSE_W-1:0] cause_o
);

  logic in_user;
  logic illegal;
  logic [CAUSE_W-1:0] call_code;

  assign in_user = (mode_i == MODE_USR);
  assign illegal = in_user && (priv_op_i || sret_i);

  // environment-call cause depends on the mode it was issued from
  always_comb begin
    unique case (mode_i)
      MODE_USR: call_code = CAUSE_W'(CODE_CALL_USR);
      MODE_SUP: call_code = CAUSE_W'(CODE_CALL_SUP);
      default:  call_code = CAUSE_W'(CODE_CALL_MCH);
    endcase
  end

  // fixed priority: illegal > environment call > fault > return
  always_comb begin
    evt_o   = EVT_NONE;
    cause_o = '0;
    if (illegal) begin
      evt_o   = EVT_TRAP;
      cause_o = CAUSE_W'(CODE_ILLEGAL);
    end else if (ecall_i) begin
      evt_o   = EVT_TRAP;
      cause_o = call_code;
    end else if (fault_i) begin
      evt_o   = EVT_TRAP;
      cause_o = fault_cause_i;
    end else if (sret_i) begin
      evt_o   = EVT_RET;
    end
  end

endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
  import priv_trap_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 5,
  parameter int STRIDE_LOG2 = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  evt_e               evt_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               tbase_wr_i,
  input  logic [XLEN-1:0]    tbase_wdata_i,
  output logic [1:0]         mode_q,
  output logic [1:0]         prev_q,
  output logic [XLEN-1:0]    epc_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [XLEN-1:0]    tbase_q
);

  localparam int HI_W = XLEN - STRIDE_LOG2;

  logic wr_ok;
  assign wr_ok = tbase_wr_i && (mode_q != MODE_USR);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_MCH;
      prev_q  <= MODE_USR;
      epc_q   <= '0;
      cause_q <= '0;
    end else begin
      unique case (evt_i)
        EVT_TRAP: begin
          mode_q  <= MODE_SUP;
          prev_q  <= mode_q;
          epc_q   <= pc_i;
          cause_q <= cause_i;
        end
        EVT_RET: begin
          mode_q <= prev_q;
          prev_q <= MODE_USR;
        end
        default: ;
      endcase
    end
  end

  // table base: low bits are never stored
  logic [HI_W-1:0] tbase_hi;
  always_ff @(posedge clk) begin
    if (rst) begin
      tbase_hi <= '0;
    end else if (wr_ok) begin
      tbase_hi <= tbase_wdata_i[XLEN-1:STRIDE_LOG2];
    end
  end
  assign tbase_q = {tbase_hi, {STRIDE_LOG2{1'b0}}};

  AST_TRAP_ENTERS_SUP: assert property (@(posedge clk) disable iff (rst)
    evt_i == EVT_TRAP |=> mode_q == MODE_SUP); // R3

  AST_RET_RESTORES: assert property (@(posedge clk) disable iff (rst)
    evt_i == EVT_RET |=> mode_q == $past(prev_q) && prev_q == MODE_USR); // R4

  AST_USER_VIA_RET: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_USR && $past(mode_q) != MODE_USR) |-> $past(evt_i) == EVT_RET); // R4

  AST_USER_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (tbase_wr_i && mode_q == MODE_USR) |=> $stable(tbase_q)); // R7

endmodule

// File: rtl/trap_redirect.sv
module trap_redirect
  import priv_trap_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 5,
  parameter int STRIDE_LOG2 = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  evt_e               evt_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    tbase_i,
  input  logic [XLEN-1:0]    epc_i,
  input  logic [CAUSE_W-1:0] saved_cause_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    target_o
);

  localparam int INSN_BYTES = 4;

  logic            resume_after;
  logic [XLEN-1:0] handler_pc;
  logic [XLEN-1:0] return_pc;

  assign resume_after = (saved_cause_i == CAUSE_W'(CODE_CALL_USR)) ||
                        (saved_cause_i == CAUSE_W'(CODE_CALL_SUP)) ||
                        (saved_cause_i == CAUSE_W'(CODE_CALL_MCH));

  assign handler_pc = tbase_i + (XLEN'(cause_i) << STRIDE_LOG2);
  assign return_pc  = resume_after ? (epc_i + XLEN'(INSN_BYTES)) : epc_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_o <= 1'b0;
      target_o   <= '0;
    end else begin
      redirect_o <= (evt_i != EVT_NONE);
      if (evt_i == EVT_TRAP) begin
        target_o <= handler_pc;
      end else if (evt_i == EVT_RET) begin
        target_o <= return_pc;
      end
    end
  end

  AST_QUIET_TARGET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    evt_i == EVT_NONE |=> !redirect_o && $stable(target_o)); // R10

endmodule

// File: rtl/priv_trap_ctrl.sv
module priv_trap_ctrl
  import priv_trap_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int CAUSE_W     = 5,
  parameter int STRIDE_LOG2 = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ecall_i,
  input  logic               sret_i,
  input  logic               priv_op_i,
  input  logic               fault_i,
  input  logic [CAUSE_W-1:0] fault_cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               tbase_wr_i,
  input  logic [XLEN-1:0]    tbase_wdata_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    target_o,
  output logic [1:0]         mode_o,
  output logic [1:0]         prev_mode_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    tbase_o
);

  evt_e               evt;
  logic [CAUSE_W-1:0] new_cause;

  trap_arbiter #(.CAUSE_W(CAUSE_W)) u_arb (
    .mode_i        (mode_o),
    .ecall_i       (ecall_i),
    .sret_i        (sret_i),
    .priv_op_i     (priv_op_i),
    .fault_i       (fault_i),
    .fault_cause_i (fault_cause_i),
    .evt_o         (evt),
    .cause_o       (new_cause)
  );

  trap_state_regs #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .STRIDE_LOG2(STRIDE_LOG2)
  ) u_regs (
    .clk           (clk),
    .rst           (rst),
    .evt_i         (evt),
    .cause_i       (new_cause),
    .pc_i          (pc_i),
    .tbase_wr_i    (tbase_wr_i),
    .tbase_wdata_i (tbase_wdata_i),
    .mode_q        (mode_o),
    .prev_q        (prev_mode_o),
    .epc_q         (epc_o),
    .cause_q       (cause_o),
    .tbase_q       (tbase_o)
  );

  trap_redirect #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .STRIDE_LOG2(STRIDE_LOG2)
  ) u_redir (
    .clk           (clk),
    .rst           (rst),
    .evt_i         (evt),
    .cause_i       (new_cause),
    .tbase_i       (tbase_o),
    .epc_i         (epc_o),
    .saved_cause_i (cause_o),
    .redirect_o    (redirect_o),
    .target_o      (target_o)
  );

  AST_TRAP_TARGET: assert property (@(posedge clk) disable iff (rst)
    evt == EVT_TRAP |=> redirect_o &&
      target_o == $past(tbase_o) + (XLEN'(cause_o) << STRIDE_LOG2)); // R10

  AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (tbase_wr_i && mode_o != MODE_USR) |=>
      tbase_o[STRIDE_LOG2-1:0] == '0 &&
      tbase_o[XLEN-1:STRIDE_LOG2] == $past(tbase_wdata_i[XLEN-1:STRIDE_LOG2])); // R6

  AST_PRIV_OK_ABOVE_USER: assert property (@(posedge clk) disable iff (rst)
    (priv_op_i && mode_o != MODE_USR && !ecall_i && !fault_i && !sret_i) |=>
      !redirect_o && mode_o == $past(mode_o)); // R11

endmodule

// File: tb/priv_trap_ctrl_tb.sv
`timescale 1ns/1ps
module priv_trap_ctrl_tb;

  localparam int XLEN = 32;
  localparam int CW   = 5;

  logic            clk = 1'b0;
  logic            rst;
  logic            ecall, sret, priv, fault;
  logic [CW-1:0]   fcause;
  logic [XLEN-1:0] pc;
  logic            wr;
  logic [XLEN-1:0] wdata;
  logic            redirect;
  logic [XLEN-1:0] target;
  logic [1:0]      mode, prev;
  logic [XLEN-1:0] epc;
  logic [CW-1:0]   cause;
  logic [XLEN-1:0] tbase;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  priv_trap_ctrl #(.XLEN(XLEN), .CAUSE_W(CW)) u_dut (
    .clk(clk), .rst(rst), .ecall_i(ecall), .sret_i(sret), .priv_op_i(priv),
    .fault_i(fault), .fault_cause_i(fcause), .pc_i(pc), .tbase_wr_i(wr),
    .tbase_wdata_i(wdata), .redirect_o(redirect), .target_o(target),
    .mode_o(mode), .prev_mode_o(prev), .epc_o(epc), .cause_o(cause),
    .tbase_o(tbase)
  );

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply one request cycle at a negedge, check at the following negedge
  task automatic req(input logic e, input logic s, input logic p, input logic f,
                     input logic [CW-1:0] fc, input logic [XLEN-1:0] pcv);
    ecall = e; sret = s; priv = p; fault = f; fcause = fc; pc = pcv;
    @(negedge clk);
    ecall = 0; sret = 0; priv = 0; fault = 0; fcause = '0;
  endtask

  task automatic write_base(input logic [XLEN-1:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic expect_trap(input string tag, input logic [XLEN-1:0] tgt,
                             input int cs, input logic [1:0] pm, input logic [XLEN-1:0] ep);
    chk({tag, " redirect"}, XLEN'(redirect), 1);
    chk({tag, " target"}, target, tgt);
    chk({tag, " mode"}, XLEN'(mode), 1);
    chk({tag, " cause"}, XLEN'(cause), XLEN'(cs));
    chk({tag, " prev"}, XLEN'(prev), XLEN'(pm));
    chk({tag, " epc"}, epc, ep);
  endtask

  task automatic expect_ret(input string tag, input logic [XLEN-1:0] tgt, input logic [1:0] md);
    chk({tag, " redirect"}, XLEN'(redirect), 1);
    chk({tag, " target"}, target, tgt);
    chk({tag, " mode"}, XLEN'(mode), XLEN'(md));
    chk({tag, " prev"}, XLEN'(prev), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mode", XLEN'(mode), 3);
    chk("R1 tbase", tbase, 0);
    chk("R1 redirect", XLEN'(redirect), 0);
    chk("R1 prev", XLEN'(prev), 0);
  endtask

  task automatic t_base_align();
    write_base(32'h0000_1003);
    chk("R6 aligned base", tbase, 32'h0000_1000);
  endtask

  task automatic t_machine_ecall_and_back();
    req(1, 0, 0, 0, '0, 32'h100);
    expect_trap("R2 R3 ecall from M", 32'h102C, 11, 2'b11, 32'h100);
    req(0, 1, 0, 0, '0, 32'h180);
    expect_ret("R4 return to M after call", 32'h104, 2'b11);
    // idle: no redirect, target stays
    @(negedge clk);
    chk("R10 idle redirect", XLEN'(redirect), 0);
    chk("R10 idle target", target, 32'h104);
  endtask

  task automatic t_fault_and_drop_to_user();
    req(0, 0, 0, 1, 5'd5, 32'h200);
    expect_trap("R9 fault cause", 32'h1014, 5, 2'b11, 32'h200);
    req(0, 1, 0, 0, '0, 32'h280);
    expect_ret("R4 return after fault re-exec", 32'h200, 2'b11);
    req(0, 1, 0, 0, '0, 32'h284);
    expect_ret("R4 return to user", 32'h200, 2'b00);
  endtask

  task automatic t_user_write_ignored();
    write_base(32'h0000_2000);
    chk("R7 base unchanged", tbase, 32'h0000_1000);
    chk("R7 no redirect", XLEN'(redirect), 0);
  endtask

  task automatic t_user_ecall();
    req(1, 0, 0, 0, '0, 32'h300);
    expect_trap("R2 ecall from U", 32'h1020, 8, 2'b00, 32'h300);
  endtask

  task automatic t_sup_priv_ok();
    req(0, 0, 1, 0, '0, 32'h310);
    chk("R11 no redirect", XLEN'(redirect), 0);
    chk("R11 mode kept", XLEN'(mode), 1);
    write_base(32'h0000_2002);
    chk("R6 sup write aligned", tbase, 32'h0000_2000);
  endtask

  task automatic t_sup_ecall_chain();
    req(1, 0, 0, 0, '0, 32'h400);
    expect_trap("R2 ecall from S", 32'h2024, 9, 2'b01, 32'h400);
    req(0, 1, 0, 0, '0, 32'h480);
    expect_ret("R4 return to S", 32'h404, 2'b01);
    req(0, 1, 0, 0, '0, 32'h484);
    expect_ret("R4 S to U", 32'h404, 2'b00);
  endtask

  task automatic t_user_illegal();
    req(0, 0, 1, 0, '0, 32'h500);
    expect_trap("R5 priv op in U", 32'h2008, 2, 2'b00, 32'h500);
    req(0, 1, 0, 0, '0, 32'h580);
    expect_ret("R4 back after priv op", 32'h500, 2'b00);
    req(0, 1, 0, 0, '0, 32'h600);
    expect_trap("R5 sret in U", 32'h2008, 2, 2'b00, 32'h600);
    req(0, 1, 0, 0, '0, 32'h680);
    expect_ret("R4 back after sret trap", 32'h600, 2'b00);
  endtask

  task automatic t_priority();
    req(1, 0, 1, 0, '0, 32'h700);
    expect_trap("R8 illegal over ecall", 32'h2008, 2, 2'b00, 32'h700);
    req(0, 1, 0, 0, '0, 32'h780);
    expect_ret("R8 resume", 32'h700, 2'b00);
    req(1, 0, 0, 1, 5'd7, 32'h800);
    expect_trap("R8 ecall over fault", 32'h2020, 8, 2'b00, 32'h800);
    req(0, 1, 0, 1, 5'd7, 32'h880);
    expect_trap("R8 R9 fault over sret", 32'h201C, 7, 2'b01, 32'h880);
  endtask

  initial begin
    ecall = 0; sret = 0; priv = 0; fault = 0; fcause = '0; pc = '0;
    wr = 0; wdata = '0; rst = 1'b1;
    @(negedge clk);
    t_reset();
    t_base_align();
    t_machine_ecall_and_back();
    t_fault_and_drop_to_user();
    t_user_write_ignored();
    t_user_ecall();
    t_sup_priv_ok();
    t_sup_ecall_chain();
    t_user_illegal();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule